// File: doc/BRIEF.md
# ATA Device Mode Initialization Sequencer

After a reset, this block brings an ATA device into a state where it can carry out data transfers. On a `start` pulse it latches the drive number. It writes the device/head register on its own and waits for the device to report ready. It then issues up to five commands, always in the same order: recalibrate, PIO transfer-mode set, DMA transfer-mode set, geometry setup and multiple-sector-count setup. A command that does not apply to the current configuration is left out.

Each command is one strobe on a parallel task-file write port. The device status register is then watched until it shows DRDY set with BSY clear. If that status also carries ERR or DWF, the run stops. If the device never becomes ready, a per-wait cycle counter ends the run. Every run ends with a single-cycle `done` pulse. It carries a 2-bit result and, for a device error, the captured error register. The bus timing and the data phase belong to other logic.

The states are:
- ST_IDLE (state 0).
- ST_SELECT and ST_SELECT_WAIT, for the drive-select write and its ready wait.
- ST_RECAL/ST_RECAL_WAIT, ST_PIO/ST_PIO_WAIT, ST_DMA/ST_DMA_WAIT, ST_GEOM/ST_GEOM_WAIT and ST_MULTI/ST_MULTI_WAIT, one issue state and one wait state per command.
- ST_FINISH, which always returns to ST_IDLE.

The transitions are:
- IDLE to SELECT on `start`.
- Each issue state to its wait state after one cycle.
- A wait state to the next applicable issue state (or FINISH when none is left) on a clean ready status.
- A wait state to FINISH on a bad ready status or on timeout.

Configuration inputs must stay stable while `busy` is high.

Top module: `ata_mode_init_seq`

## Requirements
- R1: One cycle after `start` is sampled in idle, `tf_dh_wr` pulses once with `tf_devhead` = 0xA0 | (drive_sel << 4). No command strobe follows in the next cycle.
- R2: The first command is recalibrate (`tf_command` 0x10; feature, count, sector and cylinder zero). It is issued only after the drive-select wait has seen a ready status.
- R3: Commands appear only in the order recalibrate, PIO mode, DMA mode, geometry, multiple; a successful run issues exactly the applicable ones.
- R4: The PIO step (command 0xEF, feature 0x03, count 0x08 | pio_mode) runs only when `ctl_mode_adjust` and `drv_mode_known` are both 1. When it is skipped, the DMA step is skipped as well and the sequence goes on at geometry.
- R5: The DMA step (0xEF, feature 0x03) sends count 0x40 | udma_mode when `udma_en` is 1, else 0x20 | mdma_mode when `mdma_en` is 1, and is skipped when neither is set.
- R6: The geometry step (0x91) is skipped when `lba_en` is 1. Otherwise it sends cylinder = geo_cyl, count = geo_spt, sector 0, devhead low nibble = (geo_heads − 1) mod 16, and feature = low 8 bits of precomp_cyl/4 when `legacy_disk` is 1, else 0.
- R7: The multiple step (0xC6, count = multi_cnt) is skipped when multi_cnt equals 1.
- R8: A status counts as ready only with bit 6 (DRDY) set and bit 7 (BSY) clear. No command strobe occurs unless the previous cycle's status was ready.
- R9: A ready status with bit 5 (DWF) set ends the run with result 2 (fault) and err_code 0. Otherwise, with bit 0 (ERR) set, it ends with result 3 (error) and err_code = error_in of that cycle.
- R10: If a wait state sees no ready status for WAIT_LIMIT+1 consecutive cycles, the run ends with result 1 (timeout).
- R11: Every run ends with `done` high for exactly one cycle. Result 0 means all applicable steps completed.
- R12: `start` while `busy` is high has no effect.
- R13: After reset, and in the cycle after `done`, `busy` is low and a new `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (idle only) |
| drive_sel | input | 1 | Drive number, latched at start |
| ctl_mode_adjust | input | 1 | Controller can change transfer timing |
| drv_mode_known | input | 1 | Drive reported its transfer modes |
| udma_en | input | 1 | Ultra DMA selected |
| mdma_en | input | 1 | Multiword DMA selected |
| lba_en | input | 1 | Linear addressing in use |
| legacy_disk | input | 1 | Old disk type needing write precompensation |
| pio_mode | input | MODE_W | PIO mode number |
| udma_mode | input | MODE_W | Ultra DMA mode number |
| mdma_mode | input | MODE_W | Multiword DMA mode number |
| geo_cyl | input | CYL_W | Cylinder count |
| geo_heads | input | HEAD_W | Head count |
| geo_spt | input | 8 | Sectors per track |
| precomp_cyl | input | CYL_W | Write precompensation cylinder |
| multi_cnt | input | 8 | Sectors per multiple block |
| status_in | input | 8 | Device status register |
| error_in | input | 8 | Device error register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 fault, 3 error |
| err_code | output | 8 | Captured error register |
| tf_dh_wr | output | 1 | Write strobe for device/head only |
| tf_cmd_wr | output | 1 | Write strobe for a full command |
| tf_command | output | 8 | Command code |
| tf_feature | output | 8 | Feature register value |
| tf_count | output | 8 | Sector count register value |
| tf_sector | output | 8 | Sector number register value |
| tf_cyl | output | CYL_W | Cylinder register value |
| tf_devhead | output | 8 | Device/head register value |

## Verification
The main function is tried with four flag patterns, each of which separates a different skip path:
- Every step enabled with Ultra DMA, a legacy disk and a multi count of 16.
- Mode adjustment off with multiword DMA and linear addressing. This shows that losing the PIO step also drops the DMA step, and that the geometry and multiple steps vanish.
- Neither DMA type with a non-legacy disk, which separates a skipped DMA step from a skipped PIO step and shows a zero precompensation feature.
- Every step enabled with multiword DMA and a zero device latency, which shows that multiword DMA is chosen when Ultra DMA is off.

Fault and error runs inject a bad ready status at different steps. A fault run also carries ERR, which tells the DWF priority apart from plain errors. Two hangs, one in the drive-select wait and one after a command, exercise the exact timeout cycle. A start pulse in the middle of a run shows that it leaves the command count unchanged.

// File: rtl/amis_pkg.sv
package amis_pkg;

    localparam int REG_W = 8;

    // status register bit positions
    localparam int STS_BSY  = 7;
    localparam int STS_DRDY = 6;
    localparam int STS_DWF  = 5;
    localparam int STS_ERR  = 0;

    // command codes and sub-codes
    localparam logic [REG_W-1:0] CMD_RECAL     = 8'h10;
    localparam logic [REG_W-1:0] CMD_SETFEAT   = 8'hEF;
    localparam logic [REG_W-1:0] CMD_INITPARAM = 8'h91;
    localparam logic [REG_W-1:0] CMD_SETMULT   = 8'hC6;
    localparam logic [REG_W-1:0] SUB_XFERMODE  = 8'h03;
    localparam logic [REG_W-1:0] MODE_PIO_BASE  = 8'h08;
    localparam logic [REG_W-1:0] MODE_MDMA_BASE = 8'h20;
    localparam logic [REG_W-1:0] MODE_UDMA_BASE = 8'h40;
    localparam logic [REG_W-1:0] DEVHEAD_FIXED  = 8'hA0;

    typedef enum logic [3:0] {
        ST_IDLE        = 4'd0,
        ST_SELECT      = 4'd1,
        ST_SELECT_WAIT = 4'd2,
        ST_RECAL       = 4'd3,
        ST_RECAL_WAIT  = 4'd4,
        ST_PIO         = 4'd5,
        ST_PIO_WAIT    = 4'd6,
        ST_DMA         = 4'd7,
        ST_DMA_WAIT    = 4'd8,
        ST_GEOM        = 4'd9,
        ST_GEOM_WAIT   = 4'd10,
        ST_MULTI       = 4'd11,
        ST_MULTI_WAIT  = 4'd12,
        ST_FINISH      = 4'd13
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_FAULT   = 2'd2,
        RES_ERROR   = 2'd3
    } seq_result_e;

endpackage

// File: rtl/amis_wait_timer.sv
module amis_wait_timer #(
    parameter int WAIT_LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(WAIT_LIMIT);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // a freshly loaded window never reports expiry in its first wait cycle
    assert_reload_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);

endmodule

// File: rtl/amis_step_select.sv
module amis_step_select
    import amis_pkg::*;
(
    input  seq_state_e cur_wait,
    input  logic       pio_ok,
    input  logic       dma_ok,
    input  logic       geom_ok,
    input  logic       multi_ok,
    output seq_state_e next_issue
);
    seq_state_e after_geom;
    seq_state_e after_dma;

    always_comb begin
        after_geom = multi_ok ? ST_MULTI : ST_FINISH;
        after_dma  = geom_ok  ? ST_GEOM  : after_geom;
    end

    always_comb begin
        unique case (cur_wait)
            ST_SELECT_WAIT: next_issue = ST_RECAL;
            ST_RECAL_WAIT:  next_issue = pio_ok ? ST_PIO : after_dma;
            ST_PIO_WAIT:    next_issue = dma_ok ? ST_DMA : after_dma;
            ST_DMA_WAIT:    next_issue = after_dma;
            ST_GEOM_WAIT:   next_issue = after_geom;
            default:        next_issue = ST_FINISH;
        endcase
    end

endmodule

// File: rtl/amis_cmd_build.sv
module amis_cmd_build
    import amis_pkg::*;
#(
    parameter int CYL_W  = 16,
    parameter int MODE_W = 3,
    parameter int HEAD_W = 5
) (
    input  seq_state_e          state,
    input  logic                drv,
    input  logic                udma_en,
    input  logic [MODE_W-1:0]   pio_mode,
    input  logic [MODE_W-1:0]   udma_mode,
    input  logic [MODE_W-1:0]   mdma_mode,
    input  logic [CYL_W-1:0]    geo_cyl,
    input  logic [HEAD_W-1:0]   geo_heads,
    input  logic [REG_W-1:0]    geo_spt,
    input  logic [CYL_W-1:0]    precomp_cyl,
    input  logic                legacy_disk,
    input  logic [REG_W-1:0]    multi_cnt,
    output logic [REG_W-1:0]    cmd,
    output logic [REG_W-1:0]    feat,
    output logic [REG_W-1:0]    count,
    output logic [REG_W-1:0]    sect,
    output logic [CYL_W-1:0]    cyl,
    output logic [REG_W-1:0]    devhead
);
    logic [REG_W-1:0] dh_base;
    logic [3:0]       head_max;
    logic [REG_W-1:0] precomp_q;

    assign dh_base   = DEVHEAD_FIXED | {3'b000, drv, 4'b0000};
    assign head_max  = 4'(geo_heads - HEAD_W'(1));
    assign precomp_q = REG_W'(precomp_cyl >> 2);

    always_comb begin
        cmd     = '0;
        feat    = '0;
        count   = '0;
        sect    = '0;
        cyl     = '0;
        devhead = dh_base;
        unique case (state)
            ST_RECAL: cmd = CMD_RECAL;
            ST_PIO: begin
                cmd   = CMD_SETFEAT;
                feat  = SUB_XFERMODE;
                count = MODE_PIO_BASE | REG_W'(pio_mode);
            end
            ST_DMA: begin
                cmd   = CMD_SETFEAT;
                feat  = SUB_XFERMODE;
                count = udma_en ? (MODE_UDMA_BASE | REG_W'(udma_mode))
                                : (MODE_MDMA_BASE | REG_W'(mdma_mode));
            end
            ST_GEOM: begin
                cmd     = CMD_INITPARAM;
                feat    = legacy_disk ? precomp_q : '0;
                count   = geo_spt;
                cyl     = geo_cyl;
                devhead = dh_base | {4'b0000, head_max};
            end
            ST_MULTI: begin
                cmd   = CMD_SETMULT;
                count = multi_cnt;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ata_mode_init_seq.sv
module ata_mode_init_seq
    import amis_pkg::*;
#(
    parameter int CYL_W      = 16,
    parameter int MODE_W     = 3,
    parameter int HEAD_W     = 5,
    parameter int WAIT_LIMIT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              drive_sel,
    input  logic              ctl_mode_adjust,
    input  logic              drv_mode_known,
    input  logic              udma_en,
    input  logic              mdma_en,
    input  logic              lba_en,
    input  logic              legacy_disk,
    input  logic [MODE_W-1:0] pio_mode,
    input  logic [MODE_W-1:0] udma_mode,
    input  logic [MODE_W-1:0] mdma_mode,
    input  logic [CYL_W-1:0]  geo_cyl,
    input  logic [HEAD_W-1:0] geo_heads,
    input  logic [7:0]        geo_spt,
    input  logic [CYL_W-1:0]  precomp_cyl,
    input  logic [7:0]        multi_cnt,
    input  logic [7:0]        status_in,
    input  logic [7:0]        error_in,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [7:0]        err_code,
    output logic              tf_dh_wr,
    output logic              tf_cmd_wr,
    output logic [7:0]        tf_command,
    output logic [7:0]        tf_feature,
    output logic [7:0]        tf_count,
    output logic [7:0]        tf_sector,
    output logic [CYL_W-1:0]  tf_cyl,
    output logic [7:0]        tf_devhead
);
    seq_state_e  state_q, state_nx, step_nx;
    seq_result_e res_q;
    logic        drv_q;
    logic        dev_ready, dev_bad, in_wait, in_issue, tmr_expired;
    logic        unused_sts_bits;

    assign unused_sts_bits = ^status_in[4:1];
    assign dev_ready = status_in[STS_DRDY] && !status_in[STS_BSY];
    assign dev_bad   = status_in[STS_DWF] || status_in[STS_ERR];

    always_comb begin
        in_wait  = (state_q == ST_SELECT_WAIT) || (state_q == ST_RECAL_WAIT) ||
                   (state_q == ST_PIO_WAIT)    || (state_q == ST_DMA_WAIT)   ||
                   (state_q == ST_GEOM_WAIT)   || (state_q == ST_MULTI_WAIT);
        in_issue = (state_q == ST_RECAL) || (state_q == ST_PIO)  ||
                   (state_q == ST_DMA)   || (state_q == ST_GEOM) ||
                   (state_q == ST_MULTI);
    end

    amis_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_issue || state_q == ST_SELECT),
        .run     (in_wait),
        .expired (tmr_expired)
    );

    amis_step_select u_steps (
        .cur_wait   (state_q),
        .pio_ok     (ctl_mode_adjust && drv_mode_known),
        .dma_ok     (udma_en || mdma_en),
        .geom_ok    (!lba_en),
        .multi_ok   (multi_cnt != 8'd1),
        .next_issue (step_nx)
    );

    amis_cmd_build #(.CYL_W(CYL_W), .MODE_W(MODE_W), .HEAD_W(HEAD_W)) u_build (
        .state       (state_q),
        .drv         (drv_q),
        .udma_en     (udma_en),
        .pio_mode    (pio_mode),
        .udma_mode   (udma_mode),
        .mdma_mode   (mdma_mode),
        .geo_cyl     (geo_cyl),
        .geo_heads   (geo_heads),
        .geo_spt     (geo_spt),
        .precomp_cyl (precomp_cyl),
        .legacy_disk (legacy_disk),
        .multi_cnt   (multi_cnt),
        .cmd         (tf_command),
        .feat        (tf_feature),
        .count       (tf_count),
        .sect        (tf_sector),
        .cyl         (tf_cyl),
        .devhead     (tf_devhead)
    );

    // next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:        if (start) state_nx = ST_SELECT;
            ST_SELECT:      state_nx = ST_SELECT_WAIT;
            ST_SELECT_WAIT: begin
                if (dev_ready)        state_nx = ST_RECAL;
                else if (tmr_expired) state_nx = ST_FINISH;
            end
            ST_RECAL:       state_nx = ST_RECAL_WAIT;
            ST_PIO:         state_nx = ST_PIO_WAIT;
            ST_DMA:         state_nx = ST_DMA_WAIT;
            ST_GEOM:        state_nx = ST_GEOM_WAIT;
            ST_MULTI:       state_nx = ST_MULTI_WAIT;
            ST_RECAL_WAIT, ST_PIO_WAIT, ST_DMA_WAIT, ST_GEOM_WAIT, ST_MULTI_WAIT: begin
                if (dev_ready)        state_nx = dev_bad ? ST_FINISH : step_nx;
                else if (tmr_expired) state_nx = ST_FINISH;
            end
            ST_FINISH:      state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // run context and outcome capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= RES_OK;
            err_code <= '0;
            drv_q    <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            res_q    <= RES_OK;
            err_code <= '0;
            drv_q    <= drive_sel;
        end else if (in_wait && dev_ready && dev_bad && state_q != ST_SELECT_WAIT) begin
            if (status_in[STS_DWF]) begin
                res_q <= RES_FAULT;
            end else begin
                res_q    <= RES_ERROR;
                err_code <= error_in;
            end
        end else if (in_wait && !dev_ready && tmr_expired) begin
            res_q <= RES_TIMEOUT;
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        tf_dh_wr  = (state_q == ST_SELECT);
        tf_cmd_wr = in_issue;
        result    = res_q;
    end

    assert_select_then_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tf_dh_wr |=> (busy && !tf_cmd_wr && !tf_dh_wr));

    assert_cmd_after_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tf_cmd_wr |-> $past(status_in[STS_DRDY] && !status_in[STS_BSY]));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_timeout_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_TIMEOUT) |-> $past(!(status_in[STS_DRDY] && !status_in[STS_BSY])));

    assert_fault_has_dwf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_FAULT) |-> $past(status_in[STS_DWF]));

    assert_error_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_ERROR) |-> (err_code == $past(error_in) && $past(status_in[STS_ERR])));

endmodule

// File: tb/ata_mode_init_seq_tb.sv
module ata_mode_init_seq_tb_top;

    localparam int LIM = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, start, drive_sel, ctl_mode_adjust, drv_mode_known;
    logic        udma_en, mdma_en, lba_en, legacy_disk;
    logic [2:0]  pio_mode, udma_mode, mdma_mode;
    logic [15:0] geo_cyl, precomp_cyl;
    logic [4:0]  geo_heads;
    logic [7:0]  geo_spt, multi_cnt, status_in, error_in;
    logic        busy, done, tf_dh_wr, tf_cmd_wr;
    logic [1:0]  result;
    logic [7:0]  err_code, tf_command, tf_feature, tf_count, tf_sector, tf_devhead;
    logic [15:0] tf_cyl;

    ata_mode_init_seq #(.WAIT_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .drive_sel(drive_sel),
        .ctl_mode_adjust(ctl_mode_adjust), .drv_mode_known(drv_mode_known),
        .udma_en(udma_en), .mdma_en(mdma_en), .lba_en(lba_en), .legacy_disk(legacy_disk),
        .pio_mode(pio_mode), .udma_mode(udma_mode), .mdma_mode(mdma_mode),
        .geo_cyl(geo_cyl), .geo_heads(geo_heads), .geo_spt(geo_spt),
        .precomp_cyl(precomp_cyl), .multi_cnt(multi_cnt),
        .status_in(status_in), .error_in(error_in),
        .busy(busy), .done(done), .result(result), .err_code(err_code),
        .tf_dh_wr(tf_dh_wr), .tf_cmd_wr(tf_cmd_wr), .tf_command(tf_command),
        .tf_feature(tf_feature), .tf_count(tf_count), .tf_sector(tf_sector),
        .tf_cyl(tf_cyl), .tf_devhead(tf_devhead)
    );

    typedef struct {
        logic [7:0]  cmd, feat, count, dh;
        logic [15:0] cyl;
        string       tag;
    } exp_cmd_t;

    localparam int P_IDLE = 0, P_SEL = 1, P_SELW = 2, P_ISSUE = 3, P_CMDW = 4, P_DONE = 5;

    int n_chk = 0, n_fail = 0;
    exp_cmd_t q[$];
    int m_phase = P_IDLE, m_tmo = 0, m_nexp = 0;
    logic [1:0] m_res = 2'd0;
    logic [7:0] m_err = 8'd0;
    logic m_drv = 1'b0;
    int dut_wr = 0;

    // device model state
    int dcnt = 0, wcount = 0, hang_at = -1, fail_at = -1;
    logic [7:0] fail_sts = 8'h41, fin_val = 8'h40;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic exp_cmd_t mk(input logic [7:0] c, f, n, d, input logic [15:0] cy, input string t);
        exp_cmd_t e;
        e.cmd = c; e.feat = f; e.count = n; e.dh = d; e.cyl = cy; e.tag = t;
        return e;
    endfunction

    task automatic build_queue();
        logic [7:0] base;
        logic [15:0] pq;
        logic [4:0] hm;
        base = 8'hA0 | (8'(drive_sel) << 4);
        pq = precomp_cyl / 16'd4;
        hm = geo_heads - 5'd1;
        q.delete();
        q.push_back(mk(8'h10, 8'h00, 8'h00, base, 16'h0, "R2"));
        if (ctl_mode_adjust && drv_mode_known) begin
            q.push_back(mk(8'hEF, 8'h03, 8'h08 + 8'(pio_mode), base, 16'h0, "R4"));
            if (udma_en)      q.push_back(mk(8'hEF, 8'h03, 8'h40 + 8'(udma_mode), base, 16'h0, "R5"));
            else if (mdma_en) q.push_back(mk(8'hEF, 8'h03, 8'h20 + 8'(mdma_mode), base, 16'h0, "R5"));
        end
        if (!lba_en)
            q.push_back(mk(8'h91, legacy_disk ? pq[7:0] : 8'h00, geo_spt,
                           base + 8'(hm[3:0]), geo_cyl, "R6"));
        if (multi_cnt != 8'd1) q.push_back(mk(8'hC6, 8'h00, multi_cnt, base, 16'h0, "R7"));
        m_nexp = q.size();
    endtask

    task automatic model_step(input logic s, input logic [7:0] sts, input logic [7:0] er);
        logic rdy;
        rdy = sts[6] && !sts[7];
        case (m_phase)
            P_IDLE: if (s) begin
                build_queue(); m_res = 2'd0; m_err = 8'd0; m_drv = drive_sel; m_phase = P_SEL;
            end
            P_SEL:  begin m_phase = P_SELW; m_tmo = 0; end
            P_SELW: begin
                if (rdy) m_phase = P_ISSUE;
                else if (m_tmo == LIM) begin m_res = 2'd1; m_phase = P_DONE; end
                else m_tmo++;
            end
            P_ISSUE: begin m_phase = P_CMDW; m_tmo = 0; void'(q.pop_front()); end
            P_CMDW: begin
                if (rdy) begin
                    if (sts[5])            begin m_res = 2'd2; m_phase = P_DONE; end
                    else if (sts[0])       begin m_res = 2'd3; m_err = er; m_phase = P_DONE; end
                    else if (q.size() == 0) begin m_res = 2'd0; m_phase = P_DONE; end
                    else m_phase = P_ISSUE;
                end else if (m_tmo == LIM) begin m_res = 2'd1; m_phase = P_DONE; end
                else m_tmo++;
            end
            default: m_phase = P_IDLE;
        endcase
    endtask

    task automatic compare();
        string rt;
        chk("R13", "busy", 32'(busy), 32'(m_phase != P_IDLE));
        chk("R11", "done", 32'(done), 32'(m_phase == P_DONE));
        chk("R1", "tf_dh_wr", 32'(tf_dh_wr), 32'(m_phase == P_SEL));
        chk("R8", "tf_cmd_wr", 32'(tf_cmd_wr), 32'(m_phase == P_ISSUE));
        if (m_phase == P_SEL)
            chk("R1", "devhead", 32'(tf_devhead), 32'(8'hA0 | (8'(m_drv) << 4)));
        if (m_phase == P_ISSUE) begin
            chk("R3", "command order", 32'(tf_command), 32'(q[0].cmd));
            chk(q[0].tag, "feature", 32'(tf_feature), 32'(q[0].feat));
            chk(q[0].tag, "count", 32'(tf_count), 32'(q[0].count));
            chk(q[0].tag, "sector", 32'(tf_sector), 32'h0);
            chk(q[0].tag, "cylinder", 32'(tf_cyl), 32'(q[0].cyl));
            chk(q[0].tag, "devhead", 32'(tf_devhead), 32'(q[0].dh));
        end
        if (m_phase == P_DONE) begin
            rt = (m_res == 2'd0) ? "R11" : (m_res == 2'd1) ? "R10" : "R9";
            chk(rt, "result", 32'(result), 32'(m_res));
            if (m_res == 2'd3) chk("R9", "err_code", 32'(err_code), 32'(m_err));
            if (m_res == 2'd2) chk("R9", "err_code on fault", 32'(err_code), 32'h0);
        end
        if (tf_cmd_wr) dut_wr++;
    endtask

    task automatic device_update();
        int idx;
        if (tf_dh_wr || tf_cmd_wr) begin
            if (tf_cmd_wr) wcount++;
            idx = tf_cmd_wr ? wcount : 0;
            dcnt = (idx == hang_at) ? 1000000 : dcnt_lat;
            fin_val = (tf_cmd_wr && idx == fail_at) ? fail_sts : 8'h40;
        end else if (dcnt > 0) dcnt--;
        status_in = (dcnt > 0) ? 8'h80 : fin_val;
    endtask

    int dcnt_lat = 2;

    task automatic tick();
        logic s_start;
        logic [7:0] s_sts, s_err;
        s_start = start; s_sts = status_in; s_err = error_in;
        @(posedge clk); #1;
        model_step(s_start, s_sts, s_err);
        compare();
        device_update();
        start = 1'b0;
    endtask

    task automatic run_case(input int lat, input int extra_start, input string wr_tag);
        int guard;
        dcnt_lat = lat; dcnt = 0; wcount = 0; fin_val = 8'h40; status_in = 8'h40;
        dut_wr = 0;
        start = 1'b1;
        tick();
        guard = 0;
        while (m_phase != P_IDLE && guard < 2000) begin
            if (guard == extra_start) start = 1'b1;
            tick();
            guard++;
        end
        if (m_res == 2'd0) chk(wr_tag, "command count", 32'(dut_wr), 32'(m_nexp));
        repeat (2) tick();
        hang_at = -1; fail_at = -1;
    endtask

    task automatic cfg(input logic d, cm, mk_, ue, me, lb, lg, input logic [7:0] mc);
        drive_sel = d; ctl_mode_adjust = cm; drv_mode_known = mk_;
        udma_en = ue; mdma_en = me; lba_en = lb; legacy_disk = lg; multi_cnt = mc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; status_in = 8'h40; error_in = 8'h00;
        pio_mode = 3'd4; udma_mode = 3'd5; mdma_mode = 3'd2;
        geo_cyl = 16'd1023; geo_heads = 5'd16; geo_spt = 8'd63; precomp_cyl = 16'd605;
        cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd16);
        repeat (5) @(posedge clk);
        #1;
        chk("R13", "reset busy", 32'(busy), 32'h0);
        chk("R13", "reset done", 32'(done), 32'h0);
        chk("R1", "reset dh strobe", 32'(tf_dh_wr), 32'h0);
        chk("R8", "reset cmd strobe", 32'(tf_cmd_wr), 32'h0);
        rst_n = 1'b1;
        repeat (2) tick();

        // all steps, Ultra DMA, legacy precompensation
        run_case(3, -1, "R3");
        // PIO skipped drags DMA with it; LBA and multi=1 skip the rest
        cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1);
        run_case(0, -1, "R4");
        // no DMA selected, modern disk, start pulsed mid-run
        cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8);
        drv_mode_known = 1'b1; geo_heads = 5'd7; geo_cyl = 16'h1234;
        run_case(5, 6, "R12");
        // multiword DMA when Ultra DMA off, zero latency
        cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd4);
        run_case(0, -1, "R5");
        // error on the third command
        cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd16);
        fail_at = 3; fail_sts = 8'h41; error_in = 8'h04;
        run_case(2, -1, "R9");
        // fault with ERR also set on the second command
        fail_at = 2; fail_sts = 8'h61; error_in = 8'h10;
        run_case(1, -1, "R9");
        // error on the multiple step
        fail_at = 5; fail_sts = 8'h41; error_in = 8'hA5;
        run_case(0, -1, "R7");
        // hang after PIO command
        hang_at = 2;
        run_case(1, -1, "R10");
        // hang on drive select
        hang_at = 0;
        run_case(1, -1, "R10");
        // recovery run after timeouts
        error_in = 8'h00;
        run_case(1, -1, "R13");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule